// File: doc/BRIEF.md
# Host Mailbox with Firmware-Update Mode Handshake

This block models the device side of a classic keyboard-controller style host mailbox. The host sees two byte-wide locations on a simple register bus. One is a data port and the other is a command/status port. Each direction has a single one-byte buffer. A host write to either port fills the input buffer and raises the input-full flag. The device then takes a fixed, programmable number of cycles to consume the byte. At the end of that time it clears the flag and acts on the byte. A reply byte goes into the output buffer and raises the output-full flag, which a host read of the data port clears.

Two command bytes are decoded, and both concern firmware update. Command 0xB4 switches the device into scratch-RAM execution mode and replies with 0xFA. Command 0xFE returns the device to normal flash execution. If 0xFE arrives while the device is already in normal mode, the block raises a one-cycle system reset request. The scratch-mode output drives other logic in the chip. Host software polls the status location until the input buffer is empty and, where a reply is expected, until the output buffer is full.

Top module: `kbd_mbox`

## Requirements
- R1: After reset, input-full, output-full, the scratch-mode output and the reset request are all 0, and a read of the status port (0x64) returns 0x00.
- R2: A host write to the command port (0x64) or the data port (0x60) while input-full is clear sets input-full from the next cycle. Input-full stays set for exactly CONSUME_CYC cycles (default 4) and then clears.
- R3: A consumed command 0xB4 sets the scratch-mode output, writes 0xFA into the output buffer and sets output-full, all in the same cycle that input-full clears. This also holds when the device is already in scratch mode.
- R4: A host read of the data port (0x60) returns the output buffer byte in the same cycle, and output-full reads 0 from the next cycle.
- R5: A consumed command 0xFE while in scratch mode clears the scratch-mode output, gives no reply (output-full unchanged) and raises no reset request.
- R6: A consumed command 0xFE while in normal mode raises the reset request for exactly one cycle, in the cycle input-full clears, and leaves the scratch-mode output at 0.
- R7: Any other command byte, and any byte written to the data port, is consumed with the same timing but changes neither the scratch-mode output nor output-full, and raises no reset request.
- R8: A host write to either port while input-full is set is ignored: the byte already buffered is still executed and input-full clears at its original time.
- R9: A status read returns bit 1 = input-full and bit 0 = output-full with bits 7:2 zero. A read of any address other than 0x60 or 0x64 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Host register address |
| bus_wr | input | 1 | Host write strobe, one cycle per access |
| bus_rd | input | 1 | Host read strobe, one cycle per access |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data, valid in the strobe cycle |
| scratch_mode | output | 1 | 1 while the device executes from scratch RAM |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
Read data is combinational, so each read check samples bus_rdata in the strobe cycle. Every other result is registered. Input-full becomes visible one edge after the write strobe. It then remains set through the following CONSUME_CYC-1 edges and clears on edge CONSUME_CYC. The mode change, the 0xFA reply and the reset pulse all appear on that same edge, and the reset pulse is gone one edge later. The bench drives and samples on falling edges and counts these edges explicitly. It checks input-full at every step of the window, then the other results exactly at the clearing edge and one edge after it.

// File: rtl/kbd_mbox.sv
module kbd_mbox #(
  parameter int ADDR_W      = 8,
  parameter int CONSUME_CYC = 4,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 'h60,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 'h64,
  parameter logic [7:0] OP_ENTER = 8'hB4,
  parameter logic [7:0] OP_EXIT  = 8'hFE,
  parameter logic [7:0] ACK_BYTE = 8'hFA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              scratch_mode,
  output logic              reset_req
);
  localparam int CW = $clog2(CONSUME_CYC + 1);

  logic          ibf, obf, in_cmd;
  logic [7:0]    in_byte, out_byte;
  logic [CW-1:0] cnt;

  wire hit_data = bus_addr == DATA_ADDR;
  wire hit_cmd  = bus_addr == CMD_ADDR;
  wire take     = bus_wr && !ibf && (hit_data || hit_cmd);
  wire done     = ibf && cnt == '0;
  wire do_enter = done && in_cmd && in_byte == OP_ENTER;
  wire do_exit  = done && in_cmd && in_byte == OP_EXIT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ibf <= 1'b0;
      in_cmd <= 1'b0;
      in_byte <= '0;
      cnt <= '0;
    end else if (take) begin
      ibf <= 1'b1;
      in_cmd <= hit_cmd;
      in_byte <= bus_wdata;
      cnt <= CW'(CONSUME_CYC - 1);
    end else if (done) begin
      ibf <= 1'b0;
    end else if (ibf) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      obf <= 1'b0;
      out_byte <= '0;
      scratch_mode <= 1'b0;
      reset_req <= 1'b0;
    end else begin
      reset_req <= do_exit && !scratch_mode;
      if (do_enter) begin
        scratch_mode <= 1'b1;
        out_byte <= ACK_BYTE;
        obf <= 1'b1;
      end else begin
        if (do_exit) scratch_mode <= 1'b0;
        if (bus_rd && hit_data) obf <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_rd && hit_cmd)       bus_rdata = {6'b0, ibf, obf};
    else if (bus_rd && hit_data) bus_rdata = out_byte;
  end
endmodule

module kbd_mbox_chk #(
  parameter int CONSUME_CYC = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ibf,
  input logic       obf,
  input logic [7:0] out_byte,
  input logic       scratch_mode,
  input logic       reset_req
);
  logic [15:0] hi_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) hi_cnt <= '0;
    else if (ibf) hi_cnt <= hi_cnt + 1'b1;
    else hi_cnt <= '0;
  end

  AST_IBF_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) $fell(ibf) |-> hi_cnt == 16'(CONSUME_CYC)); // R2
  AST_ACK_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n) $rose(scratch_mode) |-> (obf && out_byte == 8'hFA && $fell(ibf))); // R3
  AST_OBF_SET_ON_CONSUME: assert property (@(posedge clk) disable iff (!rst_n) $rose(obf) |-> $fell(ibf)); // R3
  AST_MODE_EXIT_ON_CONSUME: assert property (@(posedge clk) disable iff (!rst_n) $fell(scratch_mode) |-> ($fell(ibf) && !reset_req)); // R5
  AST_RSTREQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n) reset_req |=> !reset_req); // R6
  AST_RSTREQ_NORMAL: assert property (@(posedge clk) disable iff (!rst_n) reset_req |-> (!scratch_mode && $fell(ibf))); // R6
endmodule

bind kbd_mbox kbd_mbox_chk #(.CONSUME_CYC(CONSUME_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .ibf(ibf), .obf(obf), .out_byte(out_byte),
  .scratch_mode(scratch_mode), .reset_req(reset_req)
);

// File: tb/kbd_mbox_bench.sv
module kbd_mbox_bench;
  localparam int N = 4;
  logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic scratch_mode, reset_req;
  int checks = 0, fails = 0, cycles = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  kbd_mbox #(.CONSUME_CYC(N)) u_kbd_mbox (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .scratch_mode(scratch_mode),
    .reset_req(reset_req)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  function automatic logic [7:0] peek_status();
    return {6'b0, u_kbd_mbox.bus_rdata[1:0]};
  endfunction

  // status sampled by a full read cycle would consume an edge; use combinational read at a negedge
  task automatic status_now(output logic [7:0] s);
    bus_addr = 8'h64; bus_rd = 1; #1 s = bus_rdata; bus_rd = 0; bus_addr = 8'h00;
  endtask

  // called right after wr() returns: write edge E0 has passed
  task automatic consume(string tag, int exp_rr);
    logic [7:0] s;
    for (int k = 0; k < N; k++) begin
      status_now(s);
      chk({tag, " R2 ibf held"}, s[1], 1);
      chk({tag, " reset_req quiet"}, reset_req, 0);
      @(negedge clk);
    end
    status_now(s);
    chk({tag, " R2 ibf cleared"}, s[1], 0);
    chk({tag, " reset_req at consume"}, reset_req, exp_rr);
  endtask

  task automatic t_reset();
    logic [7:0] s;
    rst_n = 0; repeat (3) @(negedge clk); rst_n = 1; @(negedge clk);
    rd(8'h64, s);
    chk("R1 status", s, 0);
    chk("R1 mode", scratch_mode, 0);
    chk("R1 reset_req", reset_req, 0);
  endtask

  task automatic t_exit_normal();
    wr(8'h64, 8'hFE);
    consume("R6 exit normal", 1);
    @(negedge clk);
    chk("R6 reset_req one cycle", reset_req, 0);
    chk("R6 mode stays 0", scratch_mode, 0);
  endtask

  task automatic t_enter();
    logic [7:0] s, d;
    wr(8'h64, 8'hB4);
    chk("R3 mode before consume", scratch_mode, 0);
    consume("R3 enter", 0);
    chk("R3 mode set", scratch_mode, 1);
    status_now(s);
    chk("R9 status obf only", s, 8'h01);
    rd(8'h60, d);
    chk("R4 ack byte", d, 8'hFA);
    status_now(s);
    chk("R4 obf cleared", s, 8'h00);
  endtask

  task automatic t_reenter();
    logic [7:0] s, d;
    wr(8'h64, 8'hB4);
    consume("R3 reenter", 0);
    chk("R3 mode still set", scratch_mode, 1);
    status_now(s);
    chk("R3 reenter obf", s[0], 1);
    rd(8'h60, d);
    chk("R3 reenter ack", d, 8'hFA);
  endtask

  task automatic t_unknown();
    logic [7:0] s;
    wr(8'h64, 8'h55);
    consume("R7 unknown cmd", 0);
    status_now(s);
    chk("R7 unknown no reply", s, 0);
    chk("R7 unknown mode kept", scratch_mode, 1);
    wr(8'h60, 8'hFE);
    consume("R7 data byte", 0);
    status_now(s);
    chk("R7 data no reply", s, 0);
    chk("R7 data FE not a command", scratch_mode, 1);
  endtask

  task automatic t_exit_scratch();
    logic [7:0] s;
    wr(8'h64, 8'hFE);
    consume("R5 exit", 0);
    chk("R5 mode cleared", scratch_mode, 0);
    status_now(s);
    chk("R5 no reply", s[0], 0);
    @(negedge clk);
    chk("R5 no reset_req", reset_req, 0);
  endtask

  task automatic t_overrun();
    logic [7:0] s, d;
    wr(8'h64, 8'hB4);
    @(negedge clk); bus_addr = 8'h64; bus_wdata = 8'hFE; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
    for (int k = 0; k < N - 2; k++) begin
      status_now(s);
      chk("R8 ibf held", s[1], 1);
      @(negedge clk);
    end
    status_now(s);
    chk("R8 ibf at original time", s[1], 0);
    chk("R8 first byte executed", scratch_mode, 1);
    chk("R8 reply present", s[0], 1);
    rd(8'h60, d);
    chk("R8 ack", d, 8'hFA);
    repeat (N + 2) @(negedge clk);
    chk("R8 second byte dropped", scratch_mode, 1);
  endtask

  task automatic t_bad_addr();
    logic [7:0] s, d;
    wr(8'h64, 8'hB4);
    consume("R9 setup", 0);
    rd(8'h61, d);
    chk("R9 unused address", d, 0);
    status_now(s);
    chk("R9 obf kept after other read", s, 8'h01);
    wr(8'h62, 8'hFE);
    status_now(s);
    chk("R9 write elsewhere ignored", s[1], 0);
    rd(8'h60, d);
  endtask

  initial begin
    t_reset();
    t_exit_normal();
    t_enter();
    t_reenter();
    t_unknown();
    t_exit_scratch();
    t_overrun();
    t_bad_addr();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    while (cycles < 20000) begin @(posedge clk); cycles++; end
    if (!done_flag) begin
      done_flag = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule